// File: doc/BRIEF.md
# Interleaved Dual-Channel Input Demultiplexer

This block is the digital front end of a two-channel converter. Words arrive either on one shared bus that carries samples for both channels in turn, or on two separate buses. In interleaved operation a select level steers each captured word into the first or second channel's input register. An update strobe is divided by two inside the block, and on its active phase it moves both input registers into the output registers together. A phase-align input holds the divider so that the first update edge after its release always loads. In dual-port operation the four control inputs become independent capture and update strobes, one pair for each channel, and no division takes place.

All strobes are ordinary level inputs. They are sampled on the system clock `clk`, and a rising edge is detected when a strobe is seen high after being low. Every register takes effect at the clock edge where that rise is first seen. The registered output words drive the converter cores directly.

Top module: `ilv_demux`

## Requirements
- R1: While `rst_n` is low at a clock edge, all input registers, both output registers and the divider phase clear to zero. Both outputs read 0 after reset.
- R2: With `mode_dual` = 0, a rising edge on `strb_a` captures `bus_a`. The word goes to channel A when `strb_b` is 1 at that edge and to channel B when `strb_b` is 0.
- R3: With `mode_dual` = 0 and `upd_b` high, rises on `upd_a` leave both outputs unchanged.
- R4: With `mode_dual` = 0, the first rise of `upd_a` after `upd_b` goes low copies both input registers to the outputs at once. This also holds when the divider was in its skip phase before `upd_b` was raised.
- R5: After a loading edge in interleaved mode, the next rise of `upd_a` leaves the outputs unchanged and the rise after it loads again. Loads fall on alternate edges.
- R6: If an update rise and a capture rise are seen at the same clock edge, the output takes the input register value from before that capture.
- R7: With `mode_dual` = 1, a rise of `strb_a` (or `strb_b`) captures `bus_a` (or `bus_b`) into channel A (or B). Every rise of `upd_a` (or `upd_b`) copies that channel's input register to its output, with no division.
- R8: With `mode_dual` = 1, the strobes of one channel have no effect on the other channel's output.
- R9: With `mode_dual` = 0, `bus_b` has no effect on either channel.
- R10: A strobe held high acts once. Only the clock edge that first sees it high counts, and it has no further effect until it has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_dual | input | 1 | 0 = interleaved, 1 = dual-port |
| strb_a | input | 1 | Interleaved: capture strobe. Dual: channel A capture strobe |
| upd_a | input | 1 | Interleaved: update strobe, divided by two. Dual: channel A update strobe |
| strb_b | input | 1 | Interleaved: channel select (1 = A). Dual: channel B capture strobe |
| upd_b | input | 1 | Interleaved: phase align, active high. Dual: channel B update strobe |
| bus_a | input | W | Shared bus (interleaved) or channel A bus (dual) |
| bus_b | input | W | Channel B bus, used in dual mode only |
| out_a | output | W | Channel A output register |
| out_b | output | W | Channel B output register |

## Verification
A strobe raised just after one clock edge is seen at the next edge. The register it controls changes at that edge, so every result is due one clock after the strobe goes high. The bench drives all inputs on falling edges and pulses each strobe for exactly one clock. It reads the outputs on the falling edge after the strobe is taken low, which is well after the edge that loaded them. To confirm that an edge had no effect (skip phase, held phase align, held strobe, the other channel), the bench reads the output at the same point and expects the value from before the strobe.

// File: rtl/ilv_pkg.sv
// Shared definitions for the interleaved demultiplexer.
// Assumes: the control strobes are packed in the order given by the indices below.
package ilv_pkg;
    typedef enum logic {
        MODE_ILV  = 1'b0,
        MODE_DUAL = 1'b1
    } mode_e;

    localparam int IDX_STRB_A = 0;
    localparam int IDX_UPD_A  = 1;
    localparam int IDX_STRB_B = 2;
    localparam int IDX_UPD_B  = 3;
    localparam int N_CTRL     = 4;
endpackage

// File: rtl/strobe_edge.sv
// Rising-edge detector for a group of level strobes sampled on clk.
// Assumes: the strobes are synchronous to clk. A strobe that is high when
// reset is released counts as a rise.
module strobe_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    // Keep the previous sampled level of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    // R10
    no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/phase_div.sv
// Divide-by-two gate for the update strobe. It passes the first tick after
// hold is released and every second tick after that.
// Assumes: tick is a one-cycle pulse. Phase 0 means "load on the next tick".
module phase_div (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick,
    output logic load
);
    logic skip_q;

    // Toggle the phase on each tick. Hold or reset forces the load phase.
    always_ff @(posedge clk) begin
        if (!rst_n)     skip_q <= 1'b0;
        else if (hold)  skip_q <= 1'b0;
        else if (tick)  skip_q <= ~skip_q;
    end

    assign load = tick & ~hold & ~skip_q;

    // R5
    skip_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> skip_q);
    // R5
    load_after_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold && skip_q) |=> !skip_q);
    // R4
    hold_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !skip_q);
endmodule

// File: rtl/chan_latch.sv
// One channel: an input register loaded by a capture enable and an output
// register loaded from it by an update enable.
// Assumes: the enables are one-cycle pulses. On a shared cycle the update
// uses the old input value.
module chan_latch #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic [W-1:0] cap_data,
    input  logic         upd_en,
    output logic [W-1:0] out
);
    logic [W-1:0] in_q;
    logic [W-1:0] out_q;

    // Capture the incoming word.
    always_ff @(posedge clk) begin
        if (!rst_n)      in_q <= '0;
        else if (cap_en) in_q <= cap_data;
    end

    // Transfer the held word to the output register.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (upd_en) out_q <= in_q;
    end

    assign out = out_q;

    // R6
    upd_takes_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (out_q == $past(in_q)));
    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(out_q));
endmodule

// File: rtl/ilv_demux.sv
// Interleaved / dual-port input demultiplexer for a two-channel converter.
// Maps the four control strobes to their roles for the selected mode,
// steers captures and gates updates through the divide-by-two phase.
// Assumes: in interleaved mode the select level is stable around a capture.
module ilv_demux
    import ilv_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_dual,
    input  logic         strb_a,
    input  logic         upd_a,
    input  logic         strb_b,
    input  logic         upd_b,
    input  logic [W-1:0] bus_a,
    input  logic [W-1:0] bus_b,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b
);
    localparam int NCH = 2;

    logic [N_CTRL-1:0] lvl;
    logic [N_CTRL-1:0] rise;
    logic              ilv;
    logic              ilv_load;
    logic [NCH-1:0]    cap_en;
    logic [NCH-1:0]    upd_en;
    logic [W-1:0]      cap_data [NCH];
    logic [W-1:0]      chan_out [NCH];

    // Pack the strobes for edge detection.
    always_comb begin
        lvl             = '0;
        lvl[IDX_STRB_A] = strb_a;
        lvl[IDX_UPD_A]  = upd_a;
        lvl[IDX_STRB_B] = strb_b;
        lvl[IDX_UPD_B]  = upd_b;
    end

    assign ilv = (mode_e'(mode_dual) == MODE_ILV);

    strobe_edge #(.N(N_CTRL)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .rise (rise)
    );

    phase_div u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (~ilv | upd_b),
        .tick (rise[IDX_UPD_A]),
        .load (ilv_load)
    );

    // Route captures and updates according to the mode.
    always_comb begin
        if (ilv) begin
            cap_en[0]   = rise[IDX_STRB_A] & strb_b;
            cap_en[1]   = rise[IDX_STRB_A] & ~strb_b;
            cap_data[0] = bus_a;
            cap_data[1] = bus_a;
            upd_en[0]   = ilv_load;
            upd_en[1]   = ilv_load;
        end else begin
            cap_en[0]   = rise[IDX_STRB_A];
            cap_en[1]   = rise[IDX_STRB_B];
            cap_data[0] = bus_a;
            cap_data[1] = bus_b;
            upd_en[0]   = rise[IDX_UPD_A];
            upd_en[1]   = rise[IDX_UPD_B];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_latch #(.W(W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_en  (cap_en[c]),
            .cap_data(cap_data[c]),
            .upd_en  (upd_en[c]),
            .out     (chan_out[c])
        );
    end

    assign out_a = chan_out[0];
    assign out_b = chan_out[1];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_a == '0 && out_b == '0));
    // R3
    align_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dual && upd_b) |=> ($stable(out_a) && $stable(out_b)));
    // R8
    dual_b_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dual && !rise[IDX_UPD_B]) |=> $stable(out_b));
    // R8
    dual_a_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dual && !rise[IDX_UPD_A]) |=> $stable(out_a));
endmodule

// File: tb/tb_ilv_demux.sv
module tb_ilv_demux;
    localparam int W = 14;
    localparam logic [W-1:0] MASK = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_dual = 1'b0;
    logic         strb_a = 1'b0, upd_a = 1'b0, strb_b = 1'b0, upd_b = 1'b0;
    logic [W-1:0] bus_a = '0, bus_b = '0;
    logic [W-1:0] out_a, out_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ilv_demux #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual),
        .strb_a(strb_a), .upd_a(upd_a), .strb_b(strb_b), .upd_b(upd_b),
        .bus_a(bus_a), .bus_b(bus_b), .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Interleaved capture: one-clock strobe with the given select level.
    task automatic ilv_write(input logic sel, input logic [W-1:0] d);
        @(negedge clk);
        strb_b = sel; bus_a = d; bus_b = ~d; strb_a = 1'b1;
        @(negedge clk);
        strb_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_upd_a();
        @(negedge clk); upd_a = 1'b1;
        @(negedge clk); upd_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_upd_b();
        @(negedge clk); upd_b = 1'b1;
        @(negedge clk); upd_b = 1'b0;
        @(negedge clk);
    endtask

    task automatic dual_write_a(input logic [W-1:0] d);
        @(negedge clk); bus_a = d; strb_a = 1'b1;
        @(negedge clk); strb_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic dual_write_b(input logic [W-1:0] d);
        @(negedge clk); bus_b = d; strb_b = 1'b1;
        @(negedge clk); strb_b = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ea, eb, p, q, r, r2, s, t, u, va, vb, prev_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_a after reset", out_a, '0);
        chk("R1 out_b after reset", out_b, '0);

        // Interleaved, phase align held high: updates are blocked.
        upd_b = 1'b1;
        ilv_write(1'b1, 14'h1234);
        pulse_upd_a();
        chk("R3 out_a while align high", out_a, '0);
        pulse_upd_a();
        chk("R3 out_b while align high", out_b, '0);
        @(negedge clk); upd_b = 1'b0;

        // Sweep of interleaved pairs: D1,D2 -> A,B on the first edge, skip on the second.
        for (int k = 0; k < 8; k++) begin
            ea = ((k * 1237) + 5) & MASK;
            eb = ((k * 2711) + 9000) & MASK;
            ilv_write(1'b1, ea);
            ilv_write(1'b0, eb);
            pulse_upd_a();
            chk("R2 R4 R9 out_a load", out_a, ea);
            chk("R2 R4 R9 out_b load", out_b, eb);
            ilv_write(1'b1, ~ea);
            pulse_upd_a();
            chk("R5 out_a skip edge", out_a, ea);
            chk("R5 out_b skip edge", out_b, eb);
        end

        // Re-alignment from the skip phase.
        ilv_write(1'b1, 14'h0aaa);
        ilv_write(1'b0, 14'h0555);
        pulse_upd_a();
        chk("R5 out_a load after skip", out_a, 14'h0aaa);
        p = 14'h3001; q = 14'h0c02;
        ilv_write(1'b1, p);
        ilv_write(1'b0, q);
        pulse_upd_b();
        pulse_upd_a();
        chk("R4 out_a first edge after align", out_a, p);
        chk("R4 out_b first edge after align", out_b, q);

        // Update and capture at the same edge: update uses the old value.
        pulse_upd_a();
        r = 14'h1111; r2 = 14'h2222; s = 14'h3333;
        ilv_write(1'b1, r);
        ilv_write(1'b0, r2);
        @(negedge clk);
        strb_b = 1'b1; bus_a = s; strb_a = 1'b1; upd_a = 1'b1;
        @(negedge clk);
        strb_a = 1'b0; upd_a = 1'b0;
        @(negedge clk);
        chk("R6 out_a takes old word", out_a, r);
        chk("R6 out_b", out_b, r2);
        pulse_upd_a();
        pulse_upd_a();
        chk("R6 new word on next load", out_a, s);

        // Held strobe acts once.
        t = 14'h0f0f; u = 14'h00f0;
        ilv_write(1'b1, t);
        pulse_upd_a();
        @(negedge clk); upd_a = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 held update loads", out_a, t);
        ilv_write(1'b1, u);
        repeat (3) @(negedge clk);
        chk("R10 held update no reload", out_a, t);
        upd_a = 1'b0;
        @(negedge clk);

        // Dual-port mode.
        strb_b = 1'b0; upd_b = 1'b0;
        @(negedge clk); mode_dual = 1'b1;
        @(negedge clk);
        prev_b = out_b;
        for (int k = 0; k < 6; k++) begin
            va = ((k * 919) + 77) & MASK;
            vb = ((k * 3301) + 4242) & MASK;
            dual_write_a(va);
            dual_write_b(vb);
            pulse_upd_a();
            chk("R7 dual out_a", out_a, va);
            chk("R8 dual out_b untouched by A", out_b, prev_b);
            dual_write_a(~va);
            pulse_upd_b();
            chk("R7 dual out_b", out_b, vb);
            chk("R8 dual out_a untouched by B", out_a, va);
            prev_b = vb;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule